// File: doc/BRIEF.md
# Converter Result Shaper

This block sits behind the digitising core of a 14-bit sampling converter. It turns the core's raw samples into the word a host reads. The core delivers one straight-binary sample per clock with a valid strobe. The block passes each sample through a fixed-latency delay line that stands in for the conversion pipeline. At the output stage it can add a signed correction of a few LSB, clamping at the code limits and flagging any clamp. It can then present the word either as straight binary or as two's complement.

A 3-bit test selector can replace the core's data, at the point where the sample enters, with fixed codes. These codes match what the core would produce when its differential inputs are forced to known levels. A power-down input empties the pipeline. After power-down is released, no valid result appears until new samples have travelled the full latency. The format and correction settings are read at the output stage. The test selector is read on entry.

Top module: `adc_result_shaper`

## Requirements
- R1: With `LATENCY` = L (default 10), a sample captured at a rising edge appears on `res_code` and `res_valid` after the (L-1)-th following edge, so L edges in total counting the capture edge. `res_valid` is high exactly for captured samples that had `raw_valid` high.
- R2: With `offset_bypass`=1 and `twos_fmt`=0, the result equals the straight-binary input code unchanged. In straight binary, 0 is negative full scale, 8192 is zero input and 16383 is positive full scale.
- R3: With `offset_bypass`=0, the signed value of `offset_val` (8-bit two's complement, -128..127) is added to the straight-binary code.
- R4: When that sum falls below 0 the result is 0, and when it exceeds 16383 the result is 16383. `res_oor` is high for exactly those samples, and low on every cycle where `res_valid` is low.
- R5: With `twos_fmt`=1, bit 13 of the corrected straight-binary code is inverted, giving -8192..8191 as two's complement.
- R6: `test_sel` values 0 and 4 pass the core sample through.
- R7: `test_sel` values 1 and 5 replace the sample with the mid-scale code 8192, before correction and formatting.
- R8: `test_sel` 3 replaces the sample with 16383 and `test_sel` 7 replaces it with 0.
- R9: `test_sel` 2 replaces the sample with 12288 and `test_sel` 6 replaces it with 4096.
- R10: An edge with `pwr_down`=1 discards the pipeline contents and drives `res_valid` low after that edge. After release, `res_valid` stays low until a new sample has travelled L edges.
- R11: `twos_fmt`, `offset_bypass` and `offset_val` take effect at the edge where a sample leaves the pipeline, not at the edge where it was captured.
- R12: After a synchronous reset, `res_code`, `res_valid` and `res_oor` are all 0. `res_code` holds its last value while `res_valid` is low.
- R13: With `offset_bypass`=1, `res_oor` stays low even for full-scale codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_code | input | 14 | Core sample, straight binary |
| raw_valid | input | 1 | Core sample strobe |
| offset_val | input | 8 | Signed correction, two's complement |
| offset_bypass | input | 1 | 1 = no correction added |
| twos_fmt | input | 1 | 1 = two's complement output |
| test_sel | input | 3 | Fixed-code injection selector |
| pwr_down | input | 1 | Flush and suppress output |
| res_code | output | 14 | Final result word |
| res_valid | output | 1 | Result strobe |
| res_oor | output | 1 | Result was clamped |

## Verification
The bench aims at the clamp boundaries: codes near 0 with the most negative correction, and codes near 16383 with the most positive one. A design that wraps instead of saturating would hand back a code from the opposite end of the scale, or leave the out-of-range flag low. Settings are toggled on every cycle while samples are in flight. A design that reads them at capture instead of at the output would format or correct samples against stale settings. Power-down pulses, including single-cycle ones, are placed in the middle of a stream. A pipeline that is not fully flushed would release stale valid samples before the refill time, and an off-by-one delay line would shift every result by one cycle. All eight test selector values are exercised, so a swapped pair of fixed codes shows up as a wrong result word.

// File: rtl/adc_shaper_pkg.sv
package adc_shaper_pkg;

    localparam int CODE_W = 14;
    localparam int OFS_W  = 8;
    localparam int SUM_W  = CODE_W + 2;

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_Q3  = {2'b11, {(CODE_W-2){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_Q1  = {2'b01, {(CODE_W-2){1'b0}}};

    typedef logic [CODE_W-1:0]       code_t;
    typedef logic signed [OFS_W-1:0] ofs_t;

    // Injection selector; values 0 and 4 both mean live data
    typedef enum logic [2:0] {
        TM_LIVE_A  = 3'd0,
        TM_MID_A   = 3'd1,
        TM_UPPER_Q = 3'd2,
        TM_TOP     = 3'd3,
        TM_LIVE_B  = 3'd4,
        TM_MID_B   = 3'd5,
        TM_LOWER_Q = 3'd6,
        TM_BOTTOM  = 3'd7
    } tmode_e;

    typedef struct packed {
        logic  vld;
        code_t code;
    } smp_t;

    typedef struct packed {
        logic  oor;
        code_t code;
    } sat_t;

    typedef struct packed {
        logic  vld;
        logic  oor;
        code_t code;
    } res_t;

    function automatic code_t pick_source(tmode_e m, code_t raw);
        code_t r;
        case (m)
            TM_MID_A, TM_MID_B: r = CODE_MID;
            TM_UPPER_Q:         r = CODE_Q3;
            TM_TOP:             r = CODE_MAX;
            TM_LOWER_Q:         r = CODE_Q1;
            TM_BOTTOM:          r = CODE_MIN;
            default:            r = raw;
        endcase
        return r;
    endfunction

    function automatic sat_t add_clamp(code_t c, ofs_t o);
        logic signed [SUM_W-1:0] sum;
        sat_t r;
        sum = $signed({2'b00, c}) + $signed({{(SUM_W-OFS_W){o[OFS_W-1]}}, o});
        if (sum < 0) begin
            r.oor  = 1'b1;
            r.code = CODE_MIN;
        end else if (sum > $signed({2'b00, CODE_MAX})) begin
            r.oor  = 1'b1;
            r.code = CODE_MAX;
        end else begin
            r.oor  = 1'b0;
            r.code = sum[CODE_W-1:0];
        end
        return r;
    endfunction

    function automatic code_t apply_format(code_t c, logic twos);
        return {c[CODE_W-1] ^ twos, c[CODE_W-2:0]};
    endfunction

endpackage

// File: rtl/shaper_inject.sv
module shaper_inject
    import adc_shaper_pkg::*;
(
    input  code_t  raw_code,
    input  logic   raw_valid,
    input  tmode_e mode,
    output smp_t   dout
);
    always_comb begin
        dout.vld  = raw_valid;
        dout.code = pick_source(mode, raw_code);
    end
endmodule

// File: rtl/shaper_delay.sv
module shaper_delay
    import adc_shaper_pkg::*;
#(
    parameter int DEPTH = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  smp_t din,
    output smp_t dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_chain
            smp_t stg [DEPTH];

            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    for (int i = 0; i < DEPTH; i++) stg[i].vld <= 1'b0;
                end else begin
                    stg[0].vld <= din.vld;
                    for (int i = 1; i < DEPTH; i++) stg[i].vld <= stg[i-1].vld;
                end
                stg[0].code <= din.code;
                for (int i = 1; i < DEPTH; i++) stg[i].code <= stg[i-1].code;
            end

            assign dout = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/shaper_out.sv
module shaper_out
    import adc_shaper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  smp_t din,
    input  ofs_t ofs,
    input  logic ofs_bypass,
    input  logic twos,
    output res_t q
);
    sat_t corr;

    always_comb begin
        if (ofs_bypass) begin
            corr.oor  = 1'b0;
            corr.code = din.code;
        end else begin
            corr = add_clamp(din.code, ofs);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (flush || !din.vld) begin
            q.vld <= 1'b0;
            q.oor <= 1'b0;
        end else begin
            q.vld  <= 1'b1;
            q.oor  <= corr.oor;
            q.code <= apply_format(corr.code, twos);
        end
    end
endmodule

// File: rtl/adc_result_shaper.sv
module adc_result_shaper
    import adc_shaper_pkg::*;
#(
    parameter int LATENCY = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [13:0] raw_code,
    input  logic        raw_valid,
    input  logic [7:0]  offset_val,
    input  logic        offset_bypass,
    input  logic        twos_fmt,
    input  logic [2:0]  test_sel,
    input  logic        pwr_down,
    output logic [13:0] res_code,
    output logic        res_valid,
    output logic        res_oor
);
    localparam int CHAIN = (LATENCY > 1) ? LATENCY - 1 : 0;

    smp_t entry_s;
    smp_t exit_s;
    res_t result;

    shaper_inject u_inject (
        .raw_code  (raw_code),
        .raw_valid (raw_valid),
        .mode      (tmode_e'(test_sel)),
        .dout      (entry_s)
    );

    shaper_delay #(.DEPTH(CHAIN)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .flush (pwr_down),
        .din   (entry_s),
        .dout  (exit_s)
    );

    shaper_out u_out (
        .clk        (clk),
        .rst        (rst),
        .flush      (pwr_down),
        .din        (exit_s),
        .ofs        ($signed(offset_val)),
        .ofs_bypass (offset_bypass),
        .twos       (twos_fmt),
        .q          (result)
    );

    assign res_code  = result.code;
    assign res_valid = result.vld;
    assign res_oor   = result.oor;
endmodule

// File: rtl/adc_shaper_chk.sv
module adc_shaper_chk #(
    parameter int LATENCY = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        pwr_down,
    input logic        offset_bypass,
    input logic        twos_fmt,
    input logic [13:0] res_code,
    input logic        res_valid,
    input logic        res_oor
);
    localparam int CW = $clog2(LATENCY + 1) + 1;

    logic [CW-1:0] since_flush;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) since_flush <= '0;
        else if (since_flush < CW'(LATENCY)) since_flush <= since_flush + 1'b1;
    end

    assert_pd_drops_valid_R10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !res_valid);

    assert_refill_time_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> since_flush >= CW'(LATENCY));

    assert_oor_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
        res_oor |-> res_valid);

    assert_bypass_no_oor_R13: assert property (@(posedge clk) disable iff (rst)
        offset_bypass |=> !res_oor);

    assert_clamp_at_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (res_oor && !$past(twos_fmt)) |-> (res_code == 14'd0 || res_code == 14'h3FFF));

    assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_code));
endmodule

bind adc_result_shaper adc_shaper_chk #(.LATENCY(LATENCY)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pwr_down      (pwr_down),
    .offset_bypass (offset_bypass),
    .twos_fmt      (twos_fmt),
    .res_code      (res_code),
    .res_valid     (res_valid),
    .res_oor       (res_oor)
);

// File: tb/tb_adc_result_shaper.sv
module tb_adc_result_shaper;
    localparam int LAT = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] raw_code = '0;
    logic        raw_valid = 1'b0;
    logic [7:0]  offset_val = '0;
    logic        offset_bypass = 1'b1;
    logic        twos_fmt = 1'b0;
    logic [2:0]  test_sel = '0;
    logic        pwr_down = 1'b0;
    logic [13:0] res_code;
    logic        res_valid;
    logic        res_oor;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit live = 0;
    bit done = 0;
    string cur_tag = "R12";

    always #2.5 clk = ~clk;

    adc_result_shaper #(.LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .raw_code(raw_code), .raw_valid(raw_valid),
        .offset_val(offset_val), .offset_bypass(offset_bypass), .twos_fmt(twos_fmt),
        .test_sel(test_sel), .pwr_down(pwr_down),
        .res_code(res_code), .res_valid(res_valid), .res_oor(res_oor)
    );

    // Reference model: queue of captured samples, settings applied on exit
    logic [14:0] q[$];
    string       tq[$];
    logic        ev = 0;
    logic        eo = 0;
    logic [13:0] ec = '0;
    string       etag = "R12";

    function automatic logic [13:0] src_code(logic [2:0] m, logic [13:0] raw);
        case (m)
            3'd1, 3'd5: return 14'd8192;
            3'd2:       return 14'd12288;
            3'd3:       return 14'd16383;
            3'd6:       return 14'd4096;
            3'd7:       return 14'd0;
            default:    return raw;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [14:0] e;
        int s;
        live = 1;
        if (rst) begin
            q.delete(); tq.delete();
            ev = 0; eo = 0; ec = '0; etag = cur_tag;
        end else if (pwr_down) begin
            q.delete(); tq.delete();
            ev = 0; eo = 0; etag = cur_tag;
        end else begin
            q.push_back({raw_valid, src_code(test_sel, raw_code)});
            tq.push_back(cur_tag);
            if (q.size() == LAT) begin
                e = q.pop_front();
                etag = tq.pop_front();
                if (e[14]) begin
                    s = int'(e[13:0]);
                    if (!offset_bypass) s = s + int'($signed(offset_val));
                    eo = 0;
                    if (s < 0) begin s = 0; eo = 1; end
                    if (s > 16383) begin s = 16383; eo = 1; end
                    ec = 14'(s);
                    if (twos_fmt) ec[13] = ~ec[13];
                    ev = 1;
                end else begin
                    ev = 0; eo = 0;
                end
            end else begin
                ev = 0; eo = 0; etag = cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            checks++;
            if (res_valid !== ev) begin
                failures++;
                $display("FAIL %s valid: got %0b expected %0b", etag, res_valid, ev);
            end
            checks++;
            if (res_oor !== eo) begin
                failures++;
                $display("FAIL %s oor: got %0b expected %0b", etag, res_oor, eo);
            end
            if (ev || rst) begin
                checks++;
                if (res_code !== ec) begin
                    failures++;
                    $display("FAIL %s code: got %0d expected %0d", etag, res_code, ec);
                end
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic feed(int n, int lo, int hi, bit gaps);
        for (int i = 0; i < n; i++) begin
            raw_code  = 14'($urandom_range(hi, lo));
            raw_valid = gaps ? ($urandom_range(3, 0) != 0) : 1'b1;
            tick();
        end
    endtask

    task automatic drain();
        raw_valid = 1'b0;
        for (int i = 0; i < LAT + 2; i++) tick();
    endtask

    initial begin
        // R12: reset state
        cur_tag = "R12";
        repeat (3) tick();
        rst = 1'b0;
        repeat (2) tick();

        // R1: single sample latency, then gapped stream
        cur_tag = "R1";
        raw_code = 14'h1234; raw_valid = 1'b1; tick();
        raw_valid = 1'b0;
        drain();
        feed(30, 0, 16383, 1);

        // R2: pass-through straight binary
        cur_tag = "R2";
        feed(20, 0, 16383, 0);
        raw_code = 14'd0;     raw_valid = 1'b1; tick();
        raw_code = 14'd8192;  tick();
        raw_code = 14'd16383; tick();

        // R3: signed correction without clamp
        cur_tag = "R3";
        offset_bypass = 1'b0;
        for (int i = 0; i < 40; i++) begin
            offset_val = 8'($urandom_range(255, 0));
            raw_code   = 14'($urandom_range(16000, 200));
            raw_valid  = 1'b1;
            tick();
        end

        // R4: clamp at both ends
        cur_tag = "R4";
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 0) begin
                offset_val = 8'h80;
                raw_code   = 14'($urandom_range(140, 0));
            end else begin
                offset_val = 8'h7F;
                raw_code   = 14'($urandom_range(16383, 16240));
            end
            raw_valid = 1'b1;
            tick();
        end

        // R13: bypass never flags
        cur_tag = "R13";
        offset_bypass = 1'b1;
        for (int i = 0; i < 20; i++) begin
            offset_val = (i % 2) ? 8'h7F : 8'h80;
            raw_code   = (i % 2) ? 14'd16383 : 14'd0;
            tick();
        end
        drain();

        // R5: two's complement with and without correction
        cur_tag = "R5";
        twos_fmt = 1'b1;
        feed(20, 0, 16383, 0);
        offset_bypass = 1'b0;
        for (int i = 0; i < 20; i++) begin
            offset_val = 8'($urandom_range(255, 0));
            raw_code   = 14'($urandom_range(16383, 0));
            tick();
        end
        offset_bypass = 1'b1;
        twos_fmt = 1'b0;
        drain();

        // R6..R9: injection modes
        for (int m = 0; m < 8; m++) begin
            case (m)
                0, 4:    cur_tag = "R6";
                1, 5:    cur_tag = "R7";
                3, 7:    cur_tag = "R8";
                default: cur_tag = "R9";
            endcase
            test_sel = 3'(m);
            feed(12, 0, 16383, 0);
        end
        cur_tag = "R8";
        offset_bypass = 1'b0;
        offset_val = 8'h05;
        test_sel = 3'd3;
        feed(6, 0, 16383, 0);
        test_sel = 3'd7;
        offset_val = 8'hFB;
        feed(6, 0, 16383, 0);
        test_sel = 3'd0;
        offset_bypass = 1'b1;
        drain();

        // R10: power down mid-stream, long and single-cycle
        cur_tag = "R10";
        feed(6, 0, 16383, 0);
        pwr_down = 1'b1; feed(3, 0, 16383, 0);
        pwr_down = 1'b0; feed(25, 0, 16383, 0);
        pwr_down = 1'b1; feed(1, 0, 16383, 0);
        pwr_down = 1'b0; feed(4, 0, 16383, 0);
        pwr_down = 1'b1; feed(1, 0, 16383, 0);
        pwr_down = 1'b0; feed(20, 0, 16383, 0);

        // R11: settings change every cycle
        cur_tag = "R11";
        for (int i = 0; i < 40; i++) begin
            twos_fmt      = i[0];
            offset_bypass = i[1];
            offset_val    = 8'($urandom_range(255, 0));
            raw_code      = 14'($urandom_range(16383, 0));
            raw_valid     = 1'b1;
            tick();
        end
        drain();

        summary();
        $finish;
    end
endmodule